// File: doc/BRIEF.md
# Dual-Channel PIO Access Controller

This block carries out the channel access command of a single-wire slave with two open-drain PIO channels. The slot-timing layer decodes the command code and pulses `cmd_start`. The controller then takes two control bytes from the master and answers with one status byte. After that it enters a data phase that runs until the next bus reset. In the data phase each bit the master writes goes to a channel flip-flop, and each bit the master reads is the sampled level of a PIO pin.

The first control byte sets up the data phase. It picks the channel or channels, sets the starting direction, and chooses whether the direction flips after every byte. For two-channel writes it also chooses whether the two outputs change together or one at a time. The block also keeps one activity latch per channel, which records any edge on the pin. The master can read the latches in the status byte and can clear them when a command starts.

Bits move over two streams of single bits. `rx_*` carries bits from the master and `tx_*` carries bits to the master, both with valid/ready handshakes. A bit moves on a clock edge where valid and ready are both high.

Back-pressure rules:
- `rx_ready` never depends on `rx_valid`.
- `tx_valid` rises only in the cycle after the master raises `tx_ready`. This is the point at which the master's read slot begins, so a read bit is sampled then and not earlier.
- Once `tx_valid` is high, `tx_bit` holds until the transfer.
- `rx_ready` and `tx_valid` are never high together.

Top module: `pio_access_ctrl`

## Requirements
- R1: After `rst_n` is released, both channel outputs are 1 (transistor off), `busy` is 0, `rx_ready` and `tx_valid` are 0, and both activity latches are 0.
- R2: While `busy` is 0, a `cmd_start` pulse starts a command. The block then accepts 16 bits on the rx stream, least significant bit first: control byte 1 followed by control byte 2. Control byte 2 has no effect.
- R3: After the 16 control bits, the block sends 8 status bits on the tx stream, least significant bit first. It takes a snapshot of the state when the last control bit is accepted. The bit layout is:
  - bit0: A flip-flop
  - bit1: B flip-flop
  - bit2: A pin level
  - bit3: B pin level
  - bit4: A activity latch
  - bit5: B activity latch
  - bit6: `chan_b_en`
  - bit7: 0
- R4: Control byte 1 bits [1:0] select the channels:
  - 01: channel A only.
  - 10: channel B only.
  - 11: both channels, with data bits alternating A then B, starting with A at the beginning of the data phase.
  - 00: no channel. Every read bit returns 1 and written bits change nothing.
- R5: Control byte 1 bit4 sets the first data direction (1 = master reads, 0 = master writes). When control byte 1 bit3 is 1, the direction flips after every 8 data bits. When bit3 is 0, the direction stays fixed.
- R6: For a two-channel write with control byte 1 bit2 = 1, the A bit is held and both outputs change on the edge that accepts the following B bit. With bit2 = 0, each output changes on the edge that accepts its own bit.
- R7: A read data bit is the synchronized level of the current channel's pin, sampled on the edge where the master's `tx_ready` is first seen.
- R8: An activity latch sets on any rising or falling edge of its synchronized pin level and holds until it is cleared. If control byte 1 bit7 is 1, both latches clear on the edge that accepts that bit. A clear on the same edge as a pin edge wins.
- R9: A `bus_reset` pulse ends any command. On the next cycle `busy`, `rx_ready` and `tx_valid` are 0. The channel outputs keep their values.
- R10: `tx_bit` stays stable while `tx_valid` is high and `tx_ready` is low. `rx_ready` and `tx_valid` are never high in the same cycle.
- R11: A `cmd_start` pulse while `busy` is 1 is ignored, and the current command continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_reset | input | 1 | Bus reset seen by the slot layer; ends the command |
| cmd_start | input | 1 | One-cycle pulse: channel access command decoded |
| rx_valid | input | 1 | Bit from master is valid |
| rx_ready | output | 1 | Block can accept a bit from master |
| rx_bit | input | 1 | Bit written by master |
| tx_valid | output | 1 | Bit to master is valid |
| tx_ready | input | 1 | Master read slot open |
| tx_bit | output | 1 | Bit read by master |
| pio_a_pin | input | 1 | Level on PIO pin A |
| pio_b_pin | input | 1 | Level on PIO pin B |
| chan_b_en | input | 1 | Channel B is fitted |
| pio_a_drive | output | 1 | Channel A flip-flop (0 turns the transistor on) |
| pio_b_drive | output | 1 | Channel B flip-flop |
| busy | output | 1 | A command is in progress |

## Verification
The assertions check the following on every cycle:
- the stream rules: a stable `tx_bit` under back-pressure and no overlap of `rx_ready` with `tx_valid`;
- the exit to idle after a bus reset, with the outputs held;
- that a start pulse is ignored mid-command;
- that a held A bit in a synchronous pair leaves the outputs unchanged;
- that the activity latch sets, holds and clears.

Other behaviour only the bench scenarios can show, because it depends on whole bit sequences:
- the status byte contents;
- the order of A and B bits;
- the direction flip after each byte;
- pin values returned on reads;
- that an empty channel selection changes nothing.

// File: rtl/pio_access_pkg.sv
package pio_access_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CTRL = 2'd1,
    PH_INFO = 2'd2,
    PH_XFER = 2'd3
  } phase_e;

  localparam int BYTE_W  = 8;
  localparam int NUM_CH  = 2;
  localparam int SEL_LSB = 0;
  localparam int IC_POS  = 2;
  localparam int TOG_POS = 3;
  localparam int DIR_POS = 4;
  localparam int CLR_POS = 7;

  typedef struct packed {
    logic en;
    logic chan;
    logic val;
    logic pair;
  } wr_req_t;

endpackage

// File: rtl/pio_pin_sync.sv
module pio_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic clr_i,
  output logic level_o,
  output logic act_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              edge_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      act_o  <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
      if (clr_i)          act_o <= 1'b0;
      else if (edge_seen) act_o <= 1'b1;
    end
  end

  assign level_o   = sync_q[STAGES-1];
  assign edge_seen = sync_q[STAGES-1] ^ prev_q;

  a_r8_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && !clr_i) |=> act_o);
  a_r8_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (act_o && !clr_i) |=> act_o);
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !act_o);

endmodule

// File: rtl/pio_chan_regs.sv
module pio_chan_regs
  import pio_access_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  wr_req_t           wr_i,
  output logic [NUM_CH-1:0] ff_o
);

  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_o   <= '1;
      pend_q <= 1'b1;
    end else if (wr_i.en) begin
      if (wr_i.pair) begin
        if (!wr_i.chan) pend_q <= wr_i.val;
        else            ff_o   <= {wr_i.val, pend_q};
      end else begin
        ff_o[wr_i.chan] <= wr_i.val;
      end
    end
  end

  // R6: a held A bit of a synchronous pair must not move either output
  a_r6_pair_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i.en && wr_i.pair && !wr_i.chan) |=> $stable(ff_o));
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i.en |=> $stable(ff_o));

endmodule

// File: rtl/pio_xfer_seq.sv
module pio_xfer_seq
  import pio_access_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              cmd_start,
  input  logic              rx_valid,
  input  logic              rx_bit,
  output logic              rx_ready,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic              tx_bit,
  input  logic [NUM_CH-1:0] pin_lvl,
  input  logic [BYTE_W-1:0] info_i,
  output logic              clr_act_o,
  output wr_req_t           wr_o,
  output logic              busy_o
);

  localparam int CW = $clog2(2 * BYTE_W);

  phase_e            phase_q;
  logic [CW-1:0]     cnt_q;
  logic [BYTE_W-1:0] ctrl_q;
  logic [BYTE_W-1:0] info_q;
  logic              dir_rd_q;
  logic              on_b_q;
  logic              tx_vld_q;
  logic              tx_q;

  logic [1:0] sel;
  logic       both;
  logic       cur_chan;
  logic       rd_val;
  logic       rx_fire;
  logic       tx_fire;
  logic       last_bit;

  assign sel      = ctrl_q[SEL_LSB +: 2];
  assign both     = (sel == 2'b11);
  assign cur_chan = both ? on_b_q : (sel == 2'b10);
  assign rd_val   = (sel == 2'b00) ? 1'b1 : pin_lvl[cur_chan];
  assign rx_ready = (phase_q == PH_CTRL) || ((phase_q == PH_XFER) && !dir_rd_q);
  assign tx_valid = tx_vld_q;
  assign tx_bit   = tx_q;
  assign rx_fire  = rx_valid && rx_ready;
  assign tx_fire  = tx_vld_q && tx_ready;
  assign last_bit = (cnt_q == CW'(BYTE_W - 1));
  assign busy_o   = (phase_q != PH_IDLE);

  assign clr_act_o = (phase_q == PH_CTRL) && rx_fire && last_bit &&
                     rx_bit && !bus_reset;

  always_comb begin
    wr_o      = '0;
    wr_o.en   = (phase_q == PH_XFER) && rx_fire && (sel != 2'b00) && !bus_reset;
    wr_o.chan = cur_chan;
    wr_o.val  = rx_bit;
    wr_o.pair = both && ctrl_q[IC_POS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      ctrl_q   <= '0;
      info_q   <= '0;
      dir_rd_q <= 1'b0;
      on_b_q   <= 1'b0;
      tx_vld_q <= 1'b0;
      tx_q     <= 1'b1;
    end else if (bus_reset) begin
      phase_q  <= PH_IDLE;
      tx_vld_q <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (cmd_start) begin
            phase_q <= PH_CTRL;
            cnt_q   <= '0;
          end
        end
        PH_CTRL: begin
          if (rx_fire) begin
            if (cnt_q < CW'(BYTE_W)) ctrl_q[cnt_q[CW-2:0]] <= rx_bit;
            if (cnt_q == CW'(2 * BYTE_W - 1)) begin
              phase_q <= PH_INFO;
              cnt_q   <= '0;
              info_q  <= info_i;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        PH_INFO: begin
          if (!tx_vld_q && tx_ready) begin
            tx_q     <= info_q[cnt_q[CW-2:0]];
            tx_vld_q <= 1'b1;
          end
          if (tx_fire) begin
            tx_vld_q <= 1'b0;
            if (last_bit) begin
              phase_q  <= PH_XFER;
              cnt_q    <= '0;
              dir_rd_q <= ctrl_q[DIR_POS];
              on_b_q   <= 1'b0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        PH_XFER: begin
          if (dir_rd_q && !tx_vld_q && tx_ready) begin
            tx_q     <= rd_val;
            tx_vld_q <= 1'b1;
          end
          if (dir_rd_q ? tx_fire : rx_fire) begin
            tx_vld_q <= 1'b0;
            cnt_q    <= last_bit ? '0 : cnt_q + 1'b1;
            if (both) on_b_q <= !on_b_q;
            if (last_bit && ctrl_q[TOG_POS]) dir_rd_q <= !dir_rd_q;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  a_r10_tx_stable: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_bit)));
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready));
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cmd_start && !bus_reset) |=> busy_o);
  a_r9_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (!busy_o && !rx_ready && !tx_valid));

endmodule

// File: rtl/pio_access_ctrl.sv
module pio_access_ctrl
  import pio_access_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset,
  input  logic cmd_start,
  input  logic rx_valid,
  output logic rx_ready,
  input  logic rx_bit,
  output logic tx_valid,
  input  logic tx_ready,
  output logic tx_bit,
  input  logic pio_a_pin,
  input  logic pio_b_pin,
  input  logic chan_b_en,
  output logic pio_a_drive,
  output logic pio_b_drive,
  output logic busy
);

  logic [NUM_CH-1:0] pins;
  logic [NUM_CH-1:0] lvl;
  logic [NUM_CH-1:0] act;
  logic [NUM_CH-1:0] ff;
  logic [BYTE_W-1:0] info;
  logic              clr_act;
  wr_req_t           wr;

  assign pins = {pio_b_pin, pio_a_pin};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pio_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (pins[g]),
      .clr_i   (clr_act),
      .level_o (lvl[g]),
      .act_o   (act[g])
    );
  end

  assign info = {1'b0, chan_b_en, act, lvl, ff};

  pio_xfer_seq seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_reset (bus_reset),
    .cmd_start (cmd_start),
    .rx_valid  (rx_valid),
    .rx_bit    (rx_bit),
    .rx_ready  (rx_ready),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_bit    (tx_bit),
    .pin_lvl   (lvl),
    .info_i    (info),
    .clr_act_o (clr_act),
    .wr_o      (wr),
    .busy_o    (busy)
  );

  pio_chan_regs regs_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_i  (wr),
    .ff_o  (ff)
  );

  assign pio_a_drive = ff[0];
  assign pio_b_drive = ff[1];

  // R9: the outputs keep their values across a bus reset
  a_r9_ff_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> $stable({pio_b_drive, pio_a_drive}));

endmodule

// File: tb/pio_access_ctrl_tb_top.sv
module pio_access_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_reset = 1'b0;
  logic cmd_start = 1'b0;
  logic rx_valid = 1'b0;
  logic rx_bit = 1'b0;
  logic tx_ready = 1'b0;
  logic chan_b_en = 1'b1;
  logic [1:0] ext = 2'b11;
  logic rx_ready, tx_valid, tx_bit, pio_a_drive, pio_b_drive, busy;
  logic pio_a_pin, pio_b_pin;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  localparam int WD_LIMIT = 150000;

  logic [1:0] ff_exp = 2'b11;
  logic       pend_exp = 1'b1;

  always #2 clk = ~clk;

  assign pio_a_pin = ext[0] & pio_a_drive;
  assign pio_b_pin = ext[1] & pio_b_drive;

  pio_access_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .cmd_start(cmd_start),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_bit(rx_bit),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_bit(tx_bit),
    .pio_a_pin(pio_a_pin), .pio_b_pin(pio_b_pin), .chan_b_en(chan_b_en),
    .pio_a_drive(pio_a_drive), .pio_b_drive(pio_b_drive), .busy(busy)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WD_LIMIT) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, WD_LIMIT);
      finish_run();
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    rx_bit   = b;
    rx_valid = 1'b1;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic recv_bit(output logic b);
    repeat (3 + ($urandom % 3)) @(negedge clk);
    tx_ready = 1'b1;
    @(negedge clk);
    while (!tx_valid) @(negedge clk);
    b = tx_bit;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      logic b;
      recv_bit(b);
      v[i] = b;
    end
  endtask

  function automatic logic [7:0] info_exp(logic [1:0] act);
    logic [1:0] lv;
    lv = ext & ff_exp;
    return {1'b0, chan_b_en, act, lv, ff_exp};
  endfunction

  // R2: start pulse and two control bytes
  task automatic start_cmd(logic [7:0] c1, logic [7:0] c2);
    @(negedge clk);
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    send_byte(c1);
    send_byte(c2);
  endtask

  task automatic end_cmd();
    @(negedge clk);
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
    check("R9 busy after bus reset", {7'd0, busy}, 8'd0);
    check("R9 outputs held", {6'd0, pio_b_drive, pio_a_drive}, {6'd0, ff_exp});
    repeat (4) @(negedge clk);
  endtask

  // data phase model: R4 R5 R6 R7
  task automatic run_data(logic [7:0] c1, int nbytes);
    logic dir_rd = c1[4];
    logic on_b = 1'b0;
    logic [1:0] sel = c1[1:0];
    for (int by = 0; by < nbytes; by++) begin
      for (int i = 0; i < 8; i++) begin
        logic ch = (sel == 2'b11) ? on_b : (sel == 2'b10);
        if (dir_rd) begin
          logic b;
          logic e;
          recv_bit(b);
          e = (sel == 2'b00) ? 1'b1 : (ext[ch] & ff_exp[ch]);
          check("R7 R4 read bit", {7'd0, b}, {7'd0, e});
        end else begin
          logic b = 1'($urandom);
          check("R10 no tx during write", {7'd0, tx_valid}, 8'd0);
          send_bit(b);
          if (sel != 2'b00) begin
            if (sel == 2'b11 && c1[2]) begin
              if (!ch) pend_exp = b;
              else ff_exp = {b, pend_exp};
            end else begin
              ff_exp[ch] = b;
            end
          end
          check("R6 R4 outputs after write bit", {6'd0, pio_b_drive, pio_a_drive},
                {6'd0, ff_exp});
        end
        if (sel == 2'b11) on_b = !on_b;
      end
      if (c1[3]) dir_rd = !dir_rd;
      check("R5 direction after byte", {7'd0, rx_ready}, {7'd0, !dir_rd});
    end
  endtask

  initial begin
    logic [7:0] v;
    int seed_set;
    seed_set = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 outputs", {6'd0, pio_b_drive, pio_a_drive}, 8'h03);
    check("R1 idle", {5'd0, busy, rx_ready, tx_valid}, 8'h00);

    // R3 R8 status with clear flag, latches start at 0
    start_cmd(8'h81, 8'hff);
    check("R10 no rx ready in status phase", {7'd0, rx_ready}, 8'd0);
    recv_byte(v);
    check("R3 R8 status byte", v, info_exp(2'b00));
    end_cmd();

    // R6 synchronous pair
    start_cmd(8'h07, 8'h00);
    recv_byte(v);
    send_bit(1'b0);
    check("R6 sync A bit held", {6'd0, pio_b_drive, pio_a_drive}, 8'h03);
    send_bit(1'b0);
    ff_exp = 2'b00;
    check("R6 sync pair applied", {6'd0, pio_b_drive, pio_a_drive}, 8'h00);
    end_cmd();

    // R6 asynchronous pair
    start_cmd(8'h03, 8'h00);
    recv_byte(v);
    send_bit(1'b1);
    ff_exp = 2'b01;
    check("R6 async A alone", {6'd0, pio_b_drive, pio_a_drive}, 8'h01);
    send_bit(1'b1);
    ff_exp = 2'b11;
    check("R6 async B", {6'd0, pio_b_drive, pio_a_drive}, 8'h03);
    end_cmd();

    // R8 latches set by pin edges, then cleared
    start_cmd(8'h02, 8'h00);
    recv_byte(v);
    check("R8 latches set", v, info_exp(2'b11));
    end_cmd();
    chan_b_en = 1'b0;
    start_cmd(8'h82, 8'h00);
    recv_byte(v);
    check("R8 R3 latches cleared", v, info_exp(2'b00));
    end_cmd();
    chan_b_en = 1'b1;

    // R4 no channel: writes ignored, reads return 1
    start_cmd(8'h18, 8'h00);
    recv_byte(v);
    run_data(8'h18, 2);
    check("R4 no-channel outputs", {6'd0, pio_b_drive, pio_a_drive}, {6'd0, ff_exp});
    end_cmd();

    // R11 start pulse during a command
    start_cmd(8'h01, 8'h00);
    recv_byte(v);
    @(negedge clk);
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    check("R11 still busy", {6'd0, busy, rx_ready}, 8'h03);
    send_bit(1'b0);
    ff_exp[0] = 1'b0;
    check("R11 data phase continues", {6'd0, pio_b_drive, pio_a_drive}, {6'd0, ff_exp});
    end_cmd();

    // R9 bus reset inside the control phase
    @(negedge clk);
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    send_byte(8'h01);
    end_cmd();

    // random commands
    for (int n = 0; n < 30; n++) begin
      logic [7:0] c1;
      c1 = 8'($urandom) & 8'h1f;
      ext = 2'($urandom);
      if (c1[4] == 1'b0) ext = 2'b11;
      repeat (5) @(negedge clk);
      start_cmd(c1, 8'($urandom));
      recv_byte(v);
      check("R3 status random", v & 8'hcf, info_exp(2'b00) & 8'hcf);
      run_data(c1, 1 + ($urandom % 3));
      end_cmd();
    end

    finish_run();
  end

endmodule